// File: doc/BRIEF.md
# Single/Quad SPI Shift Engine

The shift engine is the serial datapath of a half-duplex SPI master that can also move data four bits at a time over four bidirectional lines. A sequencer hands it one micro-operation at a time through a valid/ready pair. The operation can do one of four things: select a chip, release the chip selects, shift command bits or data words out, or shift data words in. A further operation clocks idle cycles and keeps nothing from the bus. Each operation ends with a one-cycle done pulse. A receive operation also presents the collected word in that same cycle.

The serial clock comes from the system clock through an 8-bit divider. Polarity and phase are applied per operation. Word length, bit order and lane mode (one line or four) are chosen separately for every operation. The lane mode may therefore change between operations while the same chip stays selected. In quad transmit the four lines are driven. In receive and idle-clock phases they are released.

Top module: `qspi_shift_engine`

## Requirements
- R1: After reset and whenever no operation is shifting, all chip selects are high, `sck_o` equals `cfg_cpol_i`, `sd_oe_o` is 0 and `op_ready_o` is 1.
- R2: The operation kind is taken from `op_kind_i` (0 select, 1 command, 2 idle clocks, 3 transmit, 4 receive, 5 release). Select (kind 0) drives `csn_o[op_cs_i]` low and all other chip selects high. Release (kind 5) drives all four chip selects high. Both complete with done one cycle after acceptance.
- R3: Each half of a serial bit period lasts `cfg_div_i`+1 system cycles, so one bit period lasts 2·(div+1) cycles. The first half has level cpol XOR cpha and the second half has the opposite level. A shifting operation of B bit periods raises done 2·B·(div+1) cycles after the accepting edge.
- R4: Input lines are sampled at the edge that ends the first half of each bit period. With cpha=0 this is the leading edge, and with cpha=1 it is the trailing edge.
- R5: A command (kind 1) sends N = `op_len_i[3:0]`+1 bits taken from `op_data_i[15:16-N]`. With MSB-first order, the first bit is `op_data_i[15]`. With LSB-first order (`op_lsb_i`=1), the first bit is `op_data_i[16-N]`.
- R6: A transmit (kind 3) sends the low N = `op_len_i[4:0]`+1 bits of `op_data_i` (1 to 32 bits). In single-line mode the bits go out on line 0, most significant first unless `op_lsb_i`=1.
- R7: A receive (kind 4) of N bits samples line 1 in single-line mode. When it completes, `rx_valid_o` and `done_o` are high together, and `rx_data_o` holds the word right-aligned with zeros above bit N-1.
- R8: With `op_quad_i`=1, each bit period carries up to four bits, so a word takes ceil(N/4) periods. MSB-first puts `word[N-1]` on line 3 of the first period. LSB-first puts `word[0]` on line 0. A final period with r<4 bits uses lines r-1..0, and the other lines are ignored on receive.
- R9: `sd_oe_o` is 4'hF during a quad transmit or command, 4'h1 during a single-line one, and 0 during receive, idle clocks and idle.
- R10: Idle clocks (kind 2) run `op_len_i` bit periods (0 to 63) and never raise `rx_valid_o`. A count of 0 completes one cycle after acceptance with no clock edge.
- R11: `op_ready_o` is low while an operation is shifting, and `done_o` is high for exactly one cycle per operation.
- R12: The chip selects change only on an accepted select or release. They stay put across operations of mixed lane mode, order and length in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_div_i | input | 8 | Half-period length minus one, in system cycles |
| cfg_cpol_i | input | 1 | Idle level of the serial clock |
| cfg_cpha_i | input | 1 | Sample on trailing edge when 1 |
| op_valid_i | input | 1 | Operation offered |
| op_ready_o | output | 1 | Engine can accept an operation |
| op_kind_i | input | 3 | Operation kind code |
| op_cs_i | input | 2 | Chip index for select |
| op_len_i | input | 6 | Length field (N-1 or idle-clock count) |
| op_data_i | input | 32 | Command or transmit bits |
| op_lsb_i | input | 1 | LSB-first order |
| op_quad_i | input | 1 | Four-line mode |
| done_o | output | 1 | Operation finished (one cycle) |
| rx_valid_o | output | 1 | Received word valid |
| rx_data_o | output | 32 | Received word, right-aligned |
| sck_o | output | 1 | Serial clock |
| csn_o | output | 4 | Chip selects, active low |
| sd_o | output | 4 | Data line outputs |
| sd_oe_o | output | 4 | Data line output enables |
| sd_i | input | 4 | Data line inputs |

## Verification
The bench plays the role of a slave. It changes its lines only after the edge the engine should sample on, so a design that samples on the wrong edge returns a shifted word. The bench reconstructs transmitted words from the lines it sees at that edge. Reversed bit order, a command that is not left-aligned, or a misplaced last nibble in quad mode all show up as a word mismatch. During receive the bench drives ones on the unused lines, so a design that fails to mask a partial final nibble corrupts the upper bits. Other checks cover the edge counts, cycle counts and enable patterns, which catch an off-by-one divider, a missing final period, or lines left driven during idle clocks.

// File: rtl/qse_pkg.sv
package qse_pkg;
  typedef enum logic [2:0] {
    OP_SOT   = 3'd0,
    OP_CMD   = 3'd1,
    OP_DUMMY = 3'd2,
    OP_TX    = 3'd3,
    OP_RX    = 3'd4,
    OP_EOT   = 3'd5
  } op_kind_e;

  typedef enum logic {
    ST_IDLE,
    ST_SHIFT
  } eng_st_e;
endpackage

// File: rtl/qse_clkgen.sv
module qse_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             half_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             half_q;

  assign tick_o = run_i && (cnt_q == div_i);
  assign half_o = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q  <= '0;
      half_q <= ~half_q;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/qse_lane_map.sv
module qse_lane_map #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LEN_W-1:0]  pos_i,
  input  logic              lsb_i,
  input  logic              quad_i,
  output logic [3:0]        lanes_o,
  output logic [3:0]        mask_o,
  output logic [LEN_W-1:0]  base_o,
  output logic [2:0]        step_o
);
  logic [LEN_W-1:0] rem;

  assign rem    = len_i - pos_i;
  // bits moved this period: one, or up to four in quad mode
  assign step_o = !quad_i ? 3'd1 : (rem >= LEN_W'(4)) ? 3'd4 : rem[2:0];
  // lowest word index carried on line 0
  assign base_o = lsb_i ? pos_i : (len_i - pos_i - LEN_W'(step_o));

  for (genvar l = 0; l < 4; l++) begin : g_mask
    assign mask_o[l] = (step_o > 3'(l));
  end

  assign lanes_o = 4'(word_i >> base_o) & mask_o;
endmodule

// File: rtl/qse_cs_ctrl.sv
module qse_cs_ctrl #(
  parameter int NCS  = 4,
  parameter int CS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [CS_W-1:0] sel_i,
  output logic [NCS-1:0]  csn_o
);
  for (genvar g = 0; g < NCS; g++) begin : g_cs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     csn_o[g] <= 1'b1;
      else if (set_i)  csn_o[g] <= (sel_i != CS_W'(g));
      else if (clr_i)  csn_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/qspi_shift_engine.sv
module qspi_shift_engine
  import qse_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6,
  parameter int DIV_W  = 8,
  parameter int NCS    = 4,
  parameter int CS_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic              op_valid_i,
  output logic              op_ready_o,
  input  logic [2:0]        op_kind_i,
  input  logic [CS_W-1:0]   op_cs_i,
  input  logic [LEN_W-1:0]  op_len_i,
  input  logic [DATA_W-1:0] op_data_i,
  input  logic              op_lsb_i,
  input  logic              op_quad_i,
  output logic              done_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sck_o,
  output logic [NCS-1:0]    csn_o,
  output logic [3:0]        sd_o,
  output logic [3:0]        sd_oe_o,
  input  logic [3:0]        sd_i
);
  localparam int WB = $clog2(DATA_W);

  eng_st_e          state_q;
  op_kind_e         kind_q, kind_in;
  logic [DATA_W-1:0] word_q, rx_q, ld_word, rx_ins;
  logic [LEN_W-1:0] len_q, pos_q, ld_len, pos_nxt, base;
  logic [DIV_W-1:0] div_q;
  logic             lsb_q, quad_q, cpol_q, cpha_q;
  logic             done_q, rxv_q, ld_shift;
  logic             run, accept, tick, half, tx_phase;
  logic [3:0]       lanes, mask, rx_lanes;
  logic [2:0]       step;

  assign kind_in    = op_kind_e'(op_kind_i);
  assign run        = (state_q == ST_SHIFT);
  assign op_ready_o = (state_q == ST_IDLE);
  assign accept     = op_valid_i && op_ready_o;

  always_comb begin
    ld_len   = '0;
    ld_word  = '0;
    ld_shift = 1'b0;
    unique case (kind_in)
      OP_CMD: begin
        ld_len   = LEN_W'(op_len_i[3:0]) + LEN_W'(1);
        // left-aligned command: right-justify its N bits
        ld_word  = DATA_W'(op_data_i[15:0]) >> (4'd15 - op_len_i[3:0]);
        ld_shift = 1'b1;
      end
      OP_TX, OP_RX: begin
        ld_len   = LEN_W'(op_len_i[WB-1:0]) + LEN_W'(1);
        ld_word  = op_data_i;
        ld_shift = 1'b1;
      end
      OP_DUMMY: begin
        ld_len   = op_len_i;
        ld_shift = (op_len_i != '0);
      end
      default: ;
    endcase
  end

  qse_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick),
    .half_o (half)
  );

  qse_lane_map #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_lane_map (
    .word_i  (word_q),
    .len_i   (len_q),
    .pos_i   (pos_q),
    .lsb_i   (lsb_q),
    .quad_i  (quad_q),
    .lanes_o (lanes),
    .mask_o  (mask),
    .base_o  (base),
    .step_o  (step)
  );

  qse_cs_ctrl #(.NCS(NCS), .CS_W(CS_W)) u_cs_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (accept && kind_in == OP_SOT),
    .clr_i  (accept && kind_in == OP_EOT),
    .sel_i  (op_cs_i),
    .csn_o  (csn_o)
  );

  assign tx_phase = run && (kind_q == OP_CMD || kind_q == OP_TX);
  assign sd_o     = tx_phase ? lanes : 4'h0;
  assign sd_oe_o  = !tx_phase ? 4'h0 : (quad_q ? 4'hF : 4'h1);
  assign sck_o    = run ? (cpol_q ^ cpha_q ^ half) : cfg_cpol_i;

  assign rx_lanes = quad_q ? sd_i : {3'b000, sd_i[1]};
  assign rx_ins   = DATA_W'(rx_lanes & mask) << base;
  assign pos_nxt  = pos_q + LEN_W'(step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= OP_SOT;
      word_q  <= '0;
      rx_q    <= '0;
      len_q   <= '0;
      pos_q   <= '0;
      div_q   <= '0;
      lsb_q   <= 1'b0;
      quad_q  <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      done_q  <= 1'b0;
      rxv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rxv_q  <= 1'b0;
      if (accept) begin
        kind_q <= kind_in;
        word_q <= ld_word;
        len_q  <= ld_len;
        pos_q  <= '0;
        lsb_q  <= op_lsb_i;
        quad_q <= op_quad_i && (kind_in != OP_DUMMY);
        cpol_q <= cfg_cpol_i;
        cpha_q <= cfg_cpha_i;
        div_q  <= cfg_div_i;
        rx_q   <= '0;
        if (ld_shift) state_q <= ST_SHIFT;
        else          done_q  <= 1'b1;
      end else if (run && tick) begin
        if (!half) begin
          if (kind_q == OP_RX) rx_q <= rx_q | rx_ins;
        end else if (pos_nxt >= len_q) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          rxv_q   <= (kind_q == OP_RX);
        end else begin
          pos_q <= pos_nxt;
        end
      end
    end
  end

  assign done_o     = done_q;
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rx_q;
endmodule

// File: rtl/qse_checker.sv
module qse_checker #(
  parameter int NCS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           op_valid_i,
  input logic           op_ready_o,
  input logic [NCS-1:0] csn_o,
  input logic [3:0]     sd_oe_o,
  input logic           done_o,
  input logic           rx_valid_o
);
  AST_CS_ONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~csn_o)); // R2

  AST_CS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_valid_i && op_ready_o) |=> $stable(csn_o)); // R12

  AST_OE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_ready_o |-> (sd_oe_o == 4'h0)); // R9

  AST_OE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o == 4'h0) || (sd_oe_o == 4'h1) || (sd_oe_o == 4'hF)); // R9

  AST_RXV_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> done_o); // R7

  AST_DONE_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> op_ready_o); // R11
endmodule

bind qspi_shift_engine qse_checker #(.NCS(NCS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_ready_o (op_ready_o),
  .csn_o      (csn_o),
  .sd_oe_o    (sd_oe_o),
  .done_o     (done_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/qspi_shift_engine_test.sv
module qspi_shift_engine_test;
  localparam logic [2:0] K_SOT = 3'd0, K_CMD = 3'd1, K_DUM = 3'd2,
                         K_TX = 3'd3, K_RX = 3'd4, K_EOT = 3'd5;

  typedef struct packed {
    logic [2:0]  kind;
    logic [5:0]  len;
    logic [31:0] data;
    logic        lsb;
    logic        quad;
    logic [7:0]  div;
    logic        cpol;
    logic        cpha;
    logic [31:0] slave;
    logic [31:0] expw;
    logic [5:0]  per;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{K_CMD, 6'd7,  32'h0000A5FF, 1'b0, 1'b0, 8'd1, 1'b0, 1'b0, 32'h0,        32'h000000A5, 6'd8},
    '{K_CMD, 6'd15, 32'hFFFF1234, 1'b1, 1'b0, 8'd0, 1'b1, 1'b1, 32'h0,        32'h00001234, 6'd16},
    '{K_CMD, 6'd3,  32'h0000B000, 1'b1, 1'b1, 8'd0, 1'b0, 1'b0, 32'h0,        32'h0000000B, 6'd1},
    '{K_TX,  6'd31, 32'hDEADBEEF, 1'b0, 1'b0, 8'd2, 1'b0, 1'b1, 32'h0,        32'hDEADBEEF, 6'd32},
    '{K_TX,  6'd9,  32'h0000FE6B, 1'b1, 1'b1, 8'd0, 1'b0, 1'b0, 32'h0,        32'h0000026B, 6'd3},
    '{K_TX,  6'd12, 32'h00001ABC, 1'b0, 1'b1, 8'd1, 1'b1, 1'b0, 32'h0,        32'h00001ABC, 6'd4},
    '{K_TX,  6'd0,  32'h00000001, 1'b0, 1'b0, 8'd3, 1'b0, 1'b0, 32'h0,        32'h00000001, 6'd1},
    '{K_RX,  6'd15, 32'h0,        1'b0, 1'b0, 8'd1, 1'b0, 1'b0, 32'h00C35A96, 32'h00005A96, 6'd16},
    '{K_RX,  6'd6,  32'h0,        1'b1, 1'b1, 8'd0, 1'b1, 1'b1, 32'hFFFFFF4D, 32'h0000004D, 6'd2},
    '{K_RX,  6'd31, 32'h0,        1'b0, 1'b1, 8'd0, 1'b0, 1'b1, 32'h87654321, 32'h87654321, 6'd8},
    '{K_DUM, 6'd5,  32'h0,        1'b0, 1'b1, 8'd1, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000000, 6'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_kind = '0;
  logic [1:0]  op_cs = '0;
  logic [5:0]  op_len = '0;
  logic [31:0] op_data = '0;
  logic        op_lsb = 1'b0, op_quad = 1'b0;
  logic        done, rx_valid;
  logic [31:0] rx_data;
  logic        sck;
  logic [3:0]  csn, sd_o, sd_oe, sd_i;

  int total = 0;
  int bad = 0;

  int          r_cyc, r_edges, r_rdy, r_rxv;
  logic [31:0] r_acc, r_rxd;
  logic [3:0]  r_oe;
  logic        r_done2, r_sck;

  always #5 clk = ~clk;

  qspi_shift_engine uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_div_i  (cfg_div),
    .cfg_cpol_i (cfg_cpol),
    .cfg_cpha_i (cfg_cpha),
    .op_valid_i (op_valid),
    .op_ready_o (op_ready),
    .op_kind_i  (op_kind),
    .op_cs_i    (op_cs),
    .op_len_i   (op_len),
    .op_data_i  (op_data),
    .op_lsb_i   (op_lsb),
    .op_quad_i  (op_quad),
    .done_o     (done),
    .rx_valid_o (rx_valid),
    .rx_data_o  (rx_data),
    .sck_o      (sck),
    .csn_o      (csn),
    .sd_o       (sd_o),
    .sd_oe_o    (sd_oe),
    .sd_i       (sd_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int f_step(int n, int p, bit q);
    return !q ? 1 : ((n - p) >= 4 ? 4 : n - p);
  endfunction

  function automatic int f_base(int n, int p, bit lsb, bit q);
    return lsb ? p : n - p - f_step(n, p, q);
  endfunction

  function automatic logic [3:0] f_mask(int k);
    return 4'hF >> (4 - k);
  endfunction

  // slave: word bits per R8/R7 placement, unused lines forced high
  function automatic logic [3:0] f_drive(logic [31:0] w, int n, int p, bit lsb, bit q);
    logic [3:0] m, v;
    if (p >= n) return 4'hF;
    m = f_mask(f_step(n, p, q));
    v = 4'(w >> f_base(n, p, lsb, q)) & m;
    return q ? (v | ~m) : {2'b11, v[0], 1'b1};
  endfunction

  task automatic run_op(input vec_t v);
    int   n, p, k, b;
    bit   mq;
    logic prev;
    case (v.kind)
      K_CMD:        n = int'(v.len[3:0]) + 1;
      K_TX, K_RX:   n = int'(v.len[4:0]) + 1;
      K_DUM:        n = int'(v.len);
      default:      n = 0;
    endcase
    mq = v.quad && (v.kind != K_DUM);
    p = 0;
    r_edges = 0; r_acc = '0; r_oe = '0; r_rdy = 0; r_rxv = 0; r_rxd = '0;
    cfg_div = v.div; cfg_cpol = v.cpol; cfg_cpha = v.cpha;
    sd_i = f_drive(v.slave, n, 0, v.lsb, mq);
    @(negedge clk);
    op_kind = v.kind; op_len = v.len; op_data = v.data;
    op_lsb = v.lsb; op_quad = v.quad; op_valid = 1'b1;
    prev = sck;
    @(negedge clk);
    op_valid = 1'b0;
    r_cyc = 1;
    while (1) begin
      if (sck != prev && sck == (v.cpol ^ v.cpha ^ 1'b1)) begin
        r_edges++;
        if (p < n) begin
          k = f_step(n, p, mq);
          b = f_base(n, p, v.lsb, mq);
          r_acc = r_acc | (32'(sd_o & f_mask(k)) << b);
          p = p + k;
        end
        sd_i = f_drive(v.slave, n, p, v.lsb, mq);
      end
      prev = sck;
      r_oe = r_oe | sd_oe;
      if (!done && op_ready) r_rdy++;
      if (rx_valid) r_rxv++;
      if (done) begin
        r_rxd = rx_data;
        break;
      end
      if (r_cyc > 20000) break;
      @(negedge clk);
      r_cyc++;
    end
    @(negedge clk);
    r_done2 = done;
    r_sck = sck;
  endtask

  task automatic chip_op(input logic [2:0] kind, input logic [1:0] cs);
    vec_t v;
    v = '0;
    v.kind = kind;
    op_cs = cs;
    run_op(v);
  endtask

  initial begin
    repeat (10000 * 20) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    vec_t v;
    logic [3:0] exp_oe;
    string tag;
    sd_i = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 idle state after reset
    chk("R1 csn", 32'(csn), 32'hF);
    chk("R1 oe", 32'(sd_oe), 32'h0);
    chk("R1 ready", 32'(op_ready), 32'h1);
    chk("R1 sck cpol0", 32'(sck), 32'h0);
    cfg_cpol = 1'b1;
    @(negedge clk);
    chk("R1 sck cpol1", 32'(sck), 32'h1);

    // R2 select chip 2
    chip_op(K_SOT, 2'd2);
    chk("R2 sot csn", 32'(csn), 32'hB);
    chk("R2 sot cycles", 32'(r_cyc), 32'd1);

    for (int i = 0; i < NV; i++) begin
      v = VT[i];
      run_op(v);
      if (v.kind == K_RX)       tag = "R7/R4";
      else if (v.kind == K_DUM) tag = "R10";
      else if (v.quad)          tag = "R8";
      else if (v.kind == K_CMD) tag = "R5";
      else                      tag = "R6";
      if (v.kind == K_RX && v.quad) tag = "R8/R4";
      chk($sformatf("%s word vec%0d", tag, i), (v.kind == K_RX) ? r_rxd : r_acc, v.expw);
      chk($sformatf("R3 edges vec%0d", i), 32'(r_edges), 32'(v.per));
      chk($sformatf("R3 cycles vec%0d", i), 32'(r_cyc), 32'(2 * int'(v.per) * (int'(v.div) + 1) + 1));
      exp_oe = (v.kind == K_TX || v.kind == K_CMD) ? (v.quad ? 4'hF : 4'h1) : 4'h0;
      chk($sformatf("R9 oe vec%0d", i), 32'(r_oe), 32'(exp_oe));
      chk($sformatf("R7/R10 rx_valid vec%0d", i), 32'(r_rxv), (v.kind == K_RX) ? 32'd1 : 32'd0);
      chk($sformatf("R11 ready low vec%0d", i), 32'(r_rdy), 32'd0);
      chk($sformatf("R11 done width vec%0d", i), 32'(r_done2), 32'd0);
      chk($sformatf("R1 sck idle vec%0d", i), 32'(r_sck), 32'(v.cpol));
      chk($sformatf("R12 csn held vec%0d", i), 32'(csn), 32'hB);
    end

    // R10 zero idle clocks
    v = '0;
    v.kind = K_DUM;
    run_op(v);
    chk("R10 zero count cycles", 32'(r_cyc), 32'd1);
    chk("R10 zero count edges", 32'(r_edges), 32'd0);
    chk("R12 csn after zero dummy", 32'(csn), 32'hB);

    // R2 reselect and release
    chip_op(K_SOT, 2'd0);
    chk("R2 sot cs0", 32'(csn), 32'hE);
    chip_op(K_SOT, 2'd3);
    chk("R2 sot cs3", 32'(csn), 32'h7);
    chip_op(K_EOT, 2'd0);
    chk("R2 eot csn", 32'(csn), 32'hF);
    chk("R2 eot cycles", 32'(r_cyc), 32'd1);
    chk("R1 oe after eot", 32'(sd_oe), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule